// File: doc/BRIEF.md
# Glitch-Free Base Clock Selector

This block chooses whether a chip's base clock comes from the crystal reference or from the VCO of a phase-locked loop. Software asks for the VCO through a select request bit. An 8-bit PLL setting word qualifies that request. The multiplier field sits in bits 7:4 and the range field in bits 3:0. A range of zero means the PLL is off, and the VCO is then never used. The block also reports the effective multiplier, which turns a programmed zero into one.

A change of source is run by a four-state controller in the crystal domain:

- `S_XTAL`: crystal active, steady.
- `S_TO_VCO`: handing over to the VCO.
- `S_VCO`: VCO active, steady.
- `S_TO_XTAL`: handing back to the crystal.

The transitions are:

- `S_XTAL` goes to `S_TO_VCO` when the qualified request is seen.
- `S_TO_VCO` goes to `S_VCO` once the VCO enable is observed.
- `S_VCO` goes to `S_TO_XTAL` when the qualified request drops.
- `S_TO_XTAL` goes to `S_XTAL` once the crystal enable is back.

Each clock has its own gate leg. A leg resynchronises the target and the other leg's enable through two flops. It changes its own enable only on its own falling edge. The old source is therefore shut off before the new one starts, and the merged clock stays low in between. That merged clock drives a divide-by-two flop, which produces the base clock.

Top module: `clksel_top`

## Requirements
- R1: An asynchronous reset (rst_n low) selects the crystal at once, forces base_clk low and clears vco_active.
- R2: eff_n equals pll_cfg[7:4], except that a value of 0 there gives eff_n = 1.
- R3: The two source enables are never on together, and no high or low phase of base_clk is shorter than a half-period of the slower source.
- R4: base_clk runs at exactly half the frequency of the active source: its period is twice the crystal period when vco_active is 0, and twice the VCO period when it is 1.
- R5: With sel_vco = 1 and pll_cfg[3:0] nonzero, the block moves to the VCO within 40 crystal cycles. vco_active rises only after the VCO drives the output.
- R6: With pll_cfg[3:0] = 0 the VCO is refused whatever sel_vco says. If this happens while the VCO is active, the block returns to the crystal.
- R7: Dropping sel_vco returns the block to the crystal. vco_active falls only once the crystal drives the output again.
- R8: A request that changes during a transition does not abort it. The transition completes first, and the new request is acted on afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xclk | input | 1 | Crystal reference clock; also clocks the controller |
| vclk | input | 1 | VCO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_vco | input | 1 | Request to use the VCO as the source |
| pll_cfg | input | 8 | PLL setting: multiplier in bits 7:4, range in bits 3:0 |
| base_clk | output | 1 | Divided base clock |
| vco_active | output | 1 | 1 while the VCO is the active source |
| eff_n | output | 4 | Effective multiplier (a programmed 0 reads as 1) |

## Verification
The hardest case to reach from the ports is a request that reverses while a handover is still in flight. The request must be long enough to pass the synchroniser, yet it must drop before the VCO enable comes back across the domain boundary. The stimulus raises sel_vco for exactly three crystal cycles and then lowers it. A counter of rising edges on vco_active then proves that the controller finished the move to the VCO before it returned. A free-running monitor measures every phase of base_clk across all these handovers and across a reset taken while the VCO is active.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    // bit 1: target is the VCO, bit 0: VCO reported active
    typedef enum logic [1:0] {
        S_XTAL    = 2'b00,
        S_TO_VCO  = 2'b10,
        S_VCO     = 2'b11,
        S_TO_XTAL = 2'b01
    } sel_state_t;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
module clksel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_leg.sv
`timescale 1ns/1ps
module clksel_leg #(
    parameter int   SYNC_STAGES = 2,
    parameter logic EN_RST      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_en,
    output logic en,
    output logic gclk
);
    logic want_s;
    logic other_s;
    logic en_q;

    clksel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(EN_RST)) u_want (
        .clk(clk), .rst_n(rst_n), .d(want), .q(want_s)
    );

    clksel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(~EN_RST)) u_other (
        .clk(clk), .rst_n(rst_n), .d(other_en), .q(other_s)
    );

    // enable moves only while this clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= EN_RST;
        else        en_q <= want_s & ~other_s;
    end

    assign en   = en_q;
    assign gclk = clk & en_q;
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
    import clksel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic vco_on,
    input  logic xtal_on,
    output logic want_vco,
    output logic status
);
    sel_state_t state;
    sel_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_XTAL;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_XTAL:    if (req)     nxt = S_TO_VCO;
            S_TO_VCO:  if (vco_on)  nxt = S_VCO;
            S_VCO:     if (!req)    nxt = S_TO_XTAL;
            S_TO_XTAL: if (xtal_on) nxt = S_XTAL;
            default:                nxt = S_XTAL;
        endcase
    end

    // outputs are straight state bits, so they cannot glitch
    always_comb begin
        want_vco = state[1];
        status   = state[0];
    end
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top #(
    parameter int CFG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             xclk,
    input  logic             vclk,
    input  logic             rst_n,
    input  logic             sel_vco,
    input  logic [CFG_W-1:0] pll_cfg,
    output logic             base_clk,
    output logic             vco_active,
    output logic [CFG_W/2-1:0] eff_n
);
    localparam int FIELD_W = CFG_W / 2;

    logic [FIELD_W-1:0] n_fld;
    logic [FIELD_W-1:0] l_fld;
    logic req_raw, req_s;
    logic want_vco;
    logic en_x, en_v, en_v_x;
    logic gx, gv, gclk;
    logic div_q;

    assign n_fld   = pll_cfg[CFG_W-1:FIELD_W];
    assign l_fld   = pll_cfg[FIELD_W-1:0];
    assign req_raw = sel_vco & (|l_fld);
    assign eff_n   = (n_fld == '0) ? FIELD_W'(1) : n_fld;

    clksel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk(xclk), .rst_n(rst_n), .d(req_raw), .q(req_s)
    );

    clksel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ven_sync (
        .clk(xclk), .rst_n(rst_n), .d(en_v), .q(en_v_x)
    );

    clksel_ctrl u_ctrl (
        .clk(xclk), .rst_n(rst_n), .req(req_s),
        .vco_on(en_v_x), .xtal_on(en_x),
        .want_vco(want_vco), .status(vco_active)
    );

    clksel_leg #(.SYNC_STAGES(SYNC_STAGES), .EN_RST(1'b1)) u_leg_x (
        .clk(xclk), .rst_n(rst_n), .want(~want_vco),
        .other_en(en_v), .en(en_x), .gclk(gx)
    );

    clksel_leg #(.SYNC_STAGES(SYNC_STAGES), .EN_RST(1'b0)) u_leg_v (
        .clk(vclk), .rst_n(rst_n), .want(want_vco),
        .other_en(en_x), .en(en_v), .gclk(gv)
    );

    assign gclk = gx | gv;

    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= ~div_q;
    end

    assign base_clk = div_q;
endmodule

// File: rtl/clksel_chk.sv
`timescale 1ns/1ps
module clksel_chk (
    input logic xclk,
    input logic rst_n,
    input logic en_x,
    input logic en_v,
    input logic en_v_x,
    input logic want_vco,
    input logic req_s,
    input logic vco_active
);
    always_comb begin
        if (rst_n === 1'b1) begin
            p_one_source_r3: assert (!(en_x && en_v))
                else $error("both source enables on");
        end
    end

    p_rise_status_r5: assert property (@(posedge xclk) disable iff (!rst_n)
        $rose(vco_active) |-> !en_x)
        else $error("status rose with crystal still enabled");

    p_vco_seen_r5: assert property (@(posedge xclk) disable iff (!rst_n)
        $rose(en_v_x) |-> want_vco)
        else $error("VCO enable seen without target");

    p_want_from_req_r6: assert property (@(posedge xclk) disable iff (!rst_n)
        $rose(want_vco) |-> $past(req_s))
        else $error("VCO targeted without qualified request");

    p_fall_status_r7: assert property (@(posedge xclk) disable iff (!rst_n)
        $fell(vco_active) |-> en_x)
        else $error("status fell before crystal enabled");
endmodule

bind clksel_top clksel_chk u_chk (
    .xclk(xclk), .rst_n(rst_n), .en_x(en_x), .en_v(en_v),
    .en_v_x(en_v_x), .want_vco(want_vco), .req_s(req_s),
    .vco_active(vco_active)
);

// File: tb/clksel_top_test.sv
`timescale 1ns/1ps
module clksel_top_test;
    localparam realtime XH = 4.0;   // 125 MHz crystal
    localparam realtime VH = 3.0;   // unrelated VCO

    logic       xclk = 1'b0;
    logic       vclk = 1'b0;
    logic       rst_n;
    logic       sel_vco;
    logic [7:0] pll_cfg;
    logic       base_clk;
    logic       vco_active;
    logic [3:0] eff_n;

    int tests = 0;
    int fails = 0;
    int short_phases = 0;
    int effn_bad = 0;
    int rises = 0;
    realtime last_t = -1.0;

    always #(XH) xclk = ~xclk;
    always #(VH) vclk = ~vclk;

    clksel_top uut (
        .xclk(xclk), .vclk(vclk), .rst_n(rst_n), .sel_vco(sel_vco),
        .pll_cfg(pll_cfg), .base_clk(base_clk), .vco_active(vco_active),
        .eff_n(eff_n)
    );

    // phase-width monitor (R3)
    always @(base_clk or rst_n) begin
        if (rst_n !== 1'b1) last_t = -1.0;
        else begin
            if (last_t >= 0.0 && ($realtime - last_t) < XH - 0.01) short_phases++;
            last_t = $realtime;
        end
    end

    always @(posedge vco_active) rises++;

    // per-clock model of the effective multiplier (R2)
    always @(negedge xclk) begin
        if (rst_n === 1'b1) begin
            if (eff_n !== ((pll_cfg[7:4] == 4'd0) ? 4'd1 : pll_cfg[7:4])) effn_bad++;
        end
    end

    task automatic check(input string req, input bit ok, input string act, input string exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic period(input realtime expv, input string req);
        realtime t0, p;
        @(posedge base_clk); t0 = $realtime;
        @(posedge base_clk); p = $realtime - t0;
        check(req, (p > expv - 0.1) && (p < expv + 0.1),
              $sformatf("%0.2f", p), $sformatf("%0.2f", expv));
    endtask

    task automatic wait_status(input logic v, input int maxc, input string req);
        int c;
        c = 0;
        while (vco_active !== v && c < maxc) begin
            @(negedge xclk); c++;
        end
        check(req, vco_active === v, $sformatf("%b", vco_active), $sformatf("%b", v));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge xclk);
    endtask

    initial begin
        rst_n = 1'b0; sel_vco = 1'b0; pll_cfg = 8'h00;
        #1;
        check("R1 reset", base_clk === 1'b0 && vco_active === 1'b0,
              $sformatf("%b%b", base_clk, vco_active), "00");
        #29 rst_n = 1'b1;
        idle(2);
        check("R2 n=0", eff_n === 4'd1, $sformatf("%0d", eff_n), "1");
        pll_cfg = 8'h53; #1;
        check("R2 n=5", eff_n === 4'd5, $sformatf("%0d", eff_n), "5");
        pll_cfg = 8'hF3; #1;
        check("R2 n=15", eff_n === 4'd15, $sformatf("%0d", eff_n), "15");
        period(4.0 * XH, "R4 crystal period");

        sel_vco = 1'b1;
        wait_status(1'b1, 40, "R5 switch to vco");
        period(4.0 * VH, "R4 vco period");

        sel_vco = 1'b0;
        wait_status(1'b0, 40, "R7 back to crystal");
        period(4.0 * XH, "R7 crystal period");

        pll_cfg = 8'h50; sel_vco = 1'b1;
        idle(60);
        check("R6 refuse vco", vco_active === 1'b0, $sformatf("%b", vco_active), "0");
        period(4.0 * XH, "R6 crystal kept");

        pll_cfg = 8'h52;
        wait_status(1'b1, 40, "R5 enable with L=2");
        pll_cfg = 8'h50;
        wait_status(1'b0, 40, "R6 L=0 drops vco");
        period(4.0 * XH, "R6 crystal period");

        pll_cfg = 8'h53; sel_vco = 1'b0;
        idle(20);
        begin
            int r0;
            r0 = rises;
            sel_vco = 1'b1;
            idle(3);
            sel_vco = 1'b0;
            idle(60);
            check("R8 transition completed", rises == r0 + 1,
                  $sformatf("%0d", rises - r0), "1");
            check("R8 final crystal", vco_active === 1'b0,
                  $sformatf("%b", vco_active), "0");
        end
        period(4.0 * XH, "R8 crystal period");

        sel_vco = 1'b1;
        wait_status(1'b1, 40, "R5 before reset");
        #3 rst_n = 1'b0;
        #1;
        check("R1 async reset", base_clk === 1'b0 && vco_active === 1'b0,
              $sformatf("%b%b", base_clk, vco_active), "00");
        sel_vco = 1'b0;
        #20 rst_n = 1'b1;
        period(4.0 * XH, "R1 crystal after reset");

        check("R3 phase width", short_phases == 0, $sformatf("%0d", short_phases), "0");
        check("R2 model compare", effn_bad == 0, $sformatf("%0d", effn_bad), "0");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule